// File: doc/BRIEF.md
# Dual-Port Memory Access Arbiter

This block decides who uses a single shared DRAM array that sits behind one address bus. The contenders are two processor ports, A and B, and an internal refresh requester. Each port holds its request line high until it receives its acknowledge pulse, and the refresh source does the same. A requester that loses arbitration is not told so. It is stalled, because its acknowledge is withheld until its turn has come and its memory cycle has finished.

When the arbiter grants a port, it starts a memory cycle with a one-cycle start pulse to the DRAM timing sequencer. It then waits for the sequencer's done pulse and only after that acknowledges the owner. The port-B grant output is held steady for the whole cycle and steers an external address multiplexer, so that port B's address reaches the shared bus only when port B owns the memory. A refresh cycle leaves that multiplexer where it was. A lock input lets the most recently served port keep the memory across several accesses, so that an atomic read-modify-write sequence cannot be split by the other port.

Top module: `dualport_mem_arbiter`

## Requirements
- R1: After reset `ackA`, `ackB`, `refAck`, `cycGo` and `grantB` are all 0.
- R2: When refresh and one or both ports are pending in the same idle cycle, the refresh cycle is started first.
- R3: When both ports are pending together, the port that was not served most recently wins. Directly after reset port A counts as the winner.
- R4: `grantB` changes only in the cycle in which `cycGo` is 1. It becomes 1 when a port-B cycle starts and 0 when a port-A cycle starts, and a refresh cycle leaves it unchanged.
- R5: An acknowledge (`ackA`, `ackB` or `refAck`) is a one-cycle pulse. It appears in the cycle right after the clock edge at which `cycDone` was sampled high, and only for the owner of that cycle.
- R6: At most one of `ackA`, `ackB` and `refAck` is 1 in any cycle, and only one memory cycle is outstanding at a time.
- R7: While `lockIn` is 1 and a port has been served since reset, the other port is held waiting. The locked port and refresh can still start cycles.
- R8: A request seen while the arbiter is idle raises `cycGo` for exactly one cycle, in the cycle after the request is first sampled.
- R9: Every request that is held high is eventually acknowledged. Two ports that request continuously are served in strict alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqA | input | 1 | Port A request, held until `ackA` |
| ackA | output | 1 | Port A cycle complete pulse |
| reqB | input | 1 | Port B request, held until `ackB` |
| ackB | output | 1 | Port B cycle complete pulse |
| lockIn | input | 1 | Keeps ownership with the last served port |
| grantB | output | 1 | 1 selects port B's address on the external multiplexer |
| refReq | input | 1 | Refresh request, held until `refAck` |
| refAck | output | 1 | Refresh cycle complete pulse |
| cycGo | output | 1 | One-cycle start pulse to the timing sequencer |
| cycDone | input | 1 | One-cycle done pulse from the timing sequencer |

## Verification
The bench raises all three requests in the same cycle to check that refresh wins. A design with the priority inverted would acknowledge a port first. Two simultaneous port requests are issued after port A alone, and then again after port B alone. A fixed-priority design would then serve the same port twice in a row, and a continuous-request run would show starvation. Under lock, port B is left pending while port A and refresh run. A design that ignored the lock would flip `grantB` and acknowledge B too early. On every clock the bench also compares the grant changes against the start pulses and the acknowledges against the done pulses, which catches a grant that switches in the middle of a cycle or an acknowledge issued before the cycle ends.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2,
    OWN_REF  = 2'd3
  } owner_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   launch;   // start a memory cycle this clock
    logic   finish;   // current memory cycle ends this clock
    owner_e pick;     // winner when launch is set
  } strobe_t;

endpackage

// File: rtl/dpa_ctrl.sv
module dpa_ctrl
  import dpa_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqA,
  input  logic    reqB,
  input  logic    refReq,
  input  logic    lockIn,
  input  logic    cycDone,
  input  logic    lastB,
  input  logic    lastValid,
  output strobe_t stb,
  output logic    busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_ACK} state_e;

  state_e state, stateNxt;
  logic   lockHold, okA, okB;
  owner_e pick;

  // Lock only binds once some port has owned the memory
  assign lockHold = lockIn && lastValid;
  assign okA      = reqA && !(lockHold && lastB);
  assign okB      = reqB && !(lockHold && !lastB);

  always_comb begin
    if (refReq)          pick = OWN_REF;
    else if (okA && okB) pick = lastB ? OWN_A : OWN_B;
    else if (okA)        pick = OWN_A;
    else if (okB)        pick = OWN_B;
    else                 pick = OWN_NONE;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (pick != OWN_NONE) stateNxt = ST_BUSY;
      ST_BUSY: if (cycDone)          stateNxt = ST_ACK;
      default:                       stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign stb.launch = (state == ST_IDLE) && (pick != OWN_NONE);
  assign stb.finish = (state == ST_BUSY) && cycDone;
  assign stb.pick   = pick;
  assign busy       = (state != ST_IDLE);

  // Pending refresh in idle must start a cycle on the next edge
  AST_REF_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && refReq) |=> (state == ST_BUSY)); // R2

  // No new cycle may start while one is outstanding
  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && !cycDone) |=> (state == ST_BUSY)); // R6

endmodule

// File: rtl/dpa_dp.sv
module dpa_dp
  import dpa_pkg::*;
#(
  parameter bit FIRST_IS_A = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic    busy,
  input  logic    cycDone,
  input  logic    lockIn,
  output logic    lastB,
  output logic    lastValid,
  output logic    grantB,
  output logic    ackA,
  output logic    ackB,
  output logic    refAck,
  output logic    cycGo
);

  owner_e owner;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owner     <= OWN_NONE;
      lastB     <= FIRST_IS_A;
      lastValid <= 1'b0;
      grantB    <= 1'b0;
      cycGo     <= 1'b0;
    end else begin
      cycGo <= stb.launch;
      if (stb.launch) begin
        owner <= stb.pick;
        if (stb.pick == OWN_A) begin
          grantB    <= 1'b0;
          lastB     <= 1'b0;
          lastValid <= 1'b1;
        end else if (stb.pick == OWN_B) begin
          grantB    <= 1'b1;
          lastB     <= 1'b1;
          lastValid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackA   <= 1'b0;
      ackB   <= 1'b0;
      refAck <= 1'b0;
    end else begin
      ackA   <= stb.finish && (owner == OWN_A);
      ackB   <= stb.finish && (owner == OWN_B);
      refAck <= stb.finish && (owner == OWN_REF);
    end
  end

  AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ackA, ackB, refAck}) <= 1); // R6

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(grantB)); // R4

  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (ackA || ackB || refAck) |-> $past(cycDone)); // R5

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (ackA || ackB || refAck) |=> !(ackA || ackB || refAck)); // R5

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cycGo |=> !cycGo); // R8

  AST_LOCK_TO_B: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantB) |-> !$past(lockIn && lastValid)); // R7

  AST_LOCK_TO_A: assert property (@(posedge clk) disable iff (!rstN)
    $fell(grantB) |-> !$past(lockIn && lastValid)); // R7

endmodule

// File: rtl/dualport_mem_arbiter.sv
module dualport_mem_arbiter
  import dpa_pkg::*;
#(
  parameter bit FIRST_IS_A = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqA,
  output logic ackA,
  input  logic reqB,
  output logic ackB,
  input  logic lockIn,
  output logic grantB,
  input  logic refReq,
  output logic refAck,
  output logic cycGo,
  input  logic cycDone
);

  strobe_t stb;
  logic    busy, lastB, lastValid;

  dpa_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqA      (reqA),
    .reqB      (reqB),
    .refReq    (refReq),
    .lockIn    (lockIn),
    .cycDone   (cycDone),
    .lastB     (lastB),
    .lastValid (lastValid),
    .stb       (stb),
    .busy      (busy)
  );

  dpa_dp #(.FIRST_IS_A(FIRST_IS_A)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busy      (busy),
    .cycDone   (cycDone),
    .lockIn    (lockIn),
    .lastB     (lastB),
    .lastValid (lastValid),
    .grantB    (grantB),
    .ackA      (ackA),
    .ackB      (ackB),
    .refAck    (refAck),
    .cycGo     (cycGo)
  );

endmodule

// File: tb/tb_dualport_mem_arbiter.sv
`timescale 1ns/1ps
module tb_dualport_mem_arbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqA = 1'b0, reqB = 1'b0, refReq = 1'b0, lockIn = 1'b0, cycDone = 1'b0;
  logic ackA, ackB, refAck, grantB, cycGo;

  int nChk = 0, nErr = 0;
  int memLat = 3;
  bit keepA = 0, keepB = 0;
  int order [0:63];   // 1=A, 2=B, 3=refresh
  int orderCnt = 0;
  logic prevGrant = 1'b0;

  always #2.5 clk = ~clk;

  dualport_mem_arbiter dut (
    .clk(clk), .rstN(rstN), .reqA(reqA), .ackA(ackA), .reqB(reqB), .ackB(ackB),
    .lockIn(lockIn), .grantB(grantB), .refReq(refReq), .refAck(refAck),
    .cycGo(cycGo), .cycDone(cycDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  endtask

  // Timing sequencer model
  initial begin
    forever begin
      @(negedge clk);
      if (cycGo) begin
        repeat (memLat) @(negedge clk);
        cycDone = 1'b1;
        @(negedge clk);
        cycDone = 1'b0;
      end
    end
  end

  // Monitor: samples just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN) begin
        if (grantB !== prevGrant)
          chk(cycGo === 1'b1, "R4 grant change without start", int'(cycGo), 1);
        prevGrant = grantB;
        if (ackA || ackB || refAck) begin
          chk((32'(ackA) + 32'(ackB) + 32'(refAck)) == 1, "R6 single ack",
              32'(ackA) + 32'(ackB) + 32'(refAck), 1);
          chk(cycDone === 1'b1, "R5 ack follows done", int'(cycDone), 1);
          if (ackA) begin
            chk(grantB === 1'b0, "R4 grant for A", int'(grantB), 0);
            order[orderCnt] = 1; orderCnt++;
            if (!keepA) reqA = 1'b0;
          end
          if (ackB) begin
            chk(grantB === 1'b1, "R4 grant for B", int'(grantB), 1);
            order[orderCnt] = 2; orderCnt++;
            if (!keepB) reqB = 1'b0;
          end
          if (refAck) begin
            order[orderCnt] = 3; orderCnt++;
            refReq = 1'b0;
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic waitCount(input int n);
    int guard = 0;
    while (orderCnt < n && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(orderCnt >= n, "R9 requests acknowledged", orderCnt, n);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(ackA === 0 && ackB === 0 && refAck === 0, "R1 acks low", int'(ackA | ackB | refAck), 0);
    chk(cycGo === 0, "R1 start low", int'(cycGo), 0);
    chk(grantB === 0, "R1 grant low", int'(grantB), 0);
  endtask

  task automatic testSingle(input bit portB);
    int base = orderCnt;
    @(negedge clk);
    if (portB) reqB = 1'b1; else reqA = 1'b1;
    @(posedge clk); #1;
    chk(cycGo === 1'b1, "R8 start in next cycle", int'(cycGo), 1);
    @(posedge clk); #1;
    chk(cycGo === 1'b0, "R8 start is one cycle", int'(cycGo), 0);
    chk(grantB === portB, "R4 grant follows port", int'(grantB), int'(portB));
    waitCount(base + 1);
    chk(order[base] == (portB ? 2 : 1), "R5 ack to owner", order[base], portB ? 2 : 1);
    @(negedge clk);
    chk(ackA === 0 && ackB === 0, "R5 ack single pulse", int'(ackA | ackB), 0);
  endtask

  task automatic testAlternate(input bit firstAlone);
    int base;
    testSingle(firstAlone);
    base = orderCnt;
    @(negedge clk);
    reqA = 1'b1; reqB = 1'b1;
    waitCount(base + 2);
    chk(order[base] == (firstAlone ? 1 : 2), "R3 other port first", order[base], firstAlone ? 1 : 2);
    chk(order[base+1] == (firstAlone ? 2 : 1), "R3 then repeat port", order[base+1], firstAlone ? 2 : 1);
  endtask

  task automatic testRefresh();
    logic g0;
    int base = orderCnt;
    @(negedge clk);
    g0 = grantB;
    reqA = 1'b1; reqB = 1'b1; refReq = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(grantB === g0, "R4 refresh keeps grant", int'(grantB), int'(g0));
    waitCount(base + 3);
    chk(order[base] == 3, "R2 refresh first", order[base], 3);
  endtask

  task automatic testLock();
    int base;
    testSingle(1'b0);          // A served last
    @(negedge clk);
    lockIn = 1'b1;
    reqB = 1'b1;
    base = orderCnt;
    repeat (20) @(negedge clk);
    chk(orderCnt == base, "R7 other port held", orderCnt, base);
    chk(grantB === 1'b0, "R7 grant held to A", int'(grantB), 0);
    reqA = 1'b1;
    waitCount(base + 1);
    chk(order[base] == 1, "R7 locked port served", order[base], 1);
    @(negedge clk);
    refReq = 1'b1;
    waitCount(base + 2);
    chk(order[base+1] == 3, "R7 refresh under lock", order[base+1], 3);
    repeat (5) @(negedge clk);
    chk(grantB === 1'b0, "R7 grant still A", int'(grantB), 0);
    lockIn = 1'b0;
    waitCount(base + 3);
    chk(order[base+2] == 2, "R9 waiting port served after unlock", order[base+2], 2);
  endtask

  task automatic testStream();
    int base = orderCnt;
    int last;
    @(negedge clk);
    keepA = 1; keepB = 1;
    reqA = 1'b1; reqB = 1'b1;
    waitCount(base + 6);
    keepA = 0; keepB = 0;
    for (int i = base + 1; i < base + 6; i++) begin
      last = order[i-1];
      chk(order[i] != last, "R9 strict alternation", order[i], last == 1 ? 2 : 1);
    end
    while (reqA || reqB) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testSingle(1'b0);
    testSingle(1'b1);
    testAlternate(1'b0);
    testAlternate(1'b1);
    testRefresh();
    memLat = 1;
    testLock();
    memLat = 4;
    testStream();
    summary();
  end

endmodule